// File: doc/BRIEF.md
# Coincidence Stub Encoder and Event Framer

Once per bunch crossing the block takes a 128-bit coincidence vector, where each bit marks a column position with a hit. It turns this vector into a short list of stub positions and sends that list as a framed event on a 16-bit output stream with valid/ready handshaking. Each event also carries a 12-bit crossing number, a 4-bit chip number, a 4-bit column (Z) address and a side bit.

A chain of priority stages picks the lowest set positions, up to seven of them, in a single cycle. The chosen indices, their count and a truncation flag are stored in an event file. The framer then sends one header word, followed by one word per stored stub.

A new event is accepted only while no frame is pending. An event offered while a frame is pending is discarded, and a one-cycle drop indication is raised.

Top module: `stub_event_packer`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `out_valid` and `evt_dropped` are low.
- R2: Stub words are sent in ascending column-index order. The words are those of the lowest set positions of the vector.
- R3: The header word is the first word of each frame. It is laid out as bit 15 = truncation flag, bits 14:12 = number of stub words that follow, bits 11:0 = crossing number.
- R4: Each stub word is laid out as bits 15:9 = column index, bit 8 = side bit, bits 7:4 = Z address, bits 3:0 = chip number.
- R5: A vector with more than 7 set bits gives truncation flag 1 and length 7, and only the 7 lowest positions are sent. A vector with exactly 7 set bits gives flag 0.
- R6: An all-zero vector gives a frame of a single header word with length 0 and flag 0.
- R7: `out_last` is high on the final word of each frame and on no other word. After that word is accepted, `out_valid` is low in the next cycle.
- R8: An event offered while a frame is still pending (`out_valid` high) is discarded and never appears on the output. `evt_dropped` is high in the following cycle only.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values in the next cycle.
- R10: An event offered while `out_valid` is low is accepted. Its header is presented in the following cycle, and each later word is presented one cycle after the word before it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | An event is offered this cycle |
| evt_hits | input | 128 | Coincidence vector, bit i = column i |
| evt_bx | input | 12 | Crossing number for the header |
| evt_chip | input | 4 | Chip number placed in every stub word |
| evt_zcol | input | 4 | Z address placed in every stub word |
| evt_side | input | 1 | Side bit placed in every stub word |
| out_ready | input | 1 | Downstream accepts the current word |
| out_valid | output | 1 | `out_data` holds a frame word |
| out_data | output | 16 | Header or stub word |
| out_last | output | 1 | Current word ends the frame |
| evt_dropped | output | 1 | The event of the previous cycle was discarded |

## Verification
The header of an accepted event is due one cycle after the edge that accepted it. Every further word is due one cycle after the previous word is accepted, and the drop flag is due one cycle after the refused offer. The bench holds a behavioural model as word queues. The model is updated at each rising edge from the inputs the DUT saw at that edge, and it is compared with the outputs at the next falling edge, so every result is checked in exactly the cycle it is due. Ready is toggled at random during parts of the run, so that held words and offers arriving during the final handshake are covered.

// File: rtl/stub_pkg.sv
`timescale 1ns/1ps
package stub_pkg;

    localparam int COLS      = 128;
    localparam int PHI_W     = 7;
    localparam int BX_W      = 12;
    localparam int LEN_W     = 3;
    localparam int TAG_W     = 4;
    localparam int WORD_W    = 16;
    localparam int MAX_STUBS = 7;

    typedef struct packed {
        logic             trunc;
        logic [LEN_W-1:0] len;
        logic [BX_W-1:0]  bx;
    } hdr_word_t;

    typedef struct packed {
        logic [PHI_W-1:0] phi;
        logic             side;
        logic [TAG_W-1:0] zcol;
        logic [TAG_W-1:0] chip;
    } stub_word_t;

    typedef struct packed {
        logic [BX_W-1:0]  bx;
        logic [TAG_W-1:0] chip;
        logic [TAG_W-1:0] zcol;
        logic             side;
    } evt_meta_t;

    function automatic logic [WORD_W-1:0] pack_hdr(input logic t,
                                                   input logic [LEN_W-1:0] n,
                                                   input logic [BX_W-1:0] bx);
        hdr_word_t h;
        h.trunc = t;
        h.len   = n;
        h.bx    = bx;
        return h;
    endfunction

    function automatic logic [WORD_W-1:0] pack_stub(input logic [PHI_W-1:0] phi,
                                                    input evt_meta_t m);
        stub_word_t s;
        s.phi  = phi;
        s.side = m.side;
        s.zcol = m.zcol;
        s.chip = m.chip;
        return s;
    endfunction

endpackage

// File: rtl/stub_prio_chain.sv
`timescale 1ns/1ps
module stub_prio_chain #(
    parameter int NCOL  = 128,
    parameter int SLOTS = 7,
    parameter int IDX_W = $clog2(NCOL)
) (
    input  logic [NCOL-1:0]             hits,
    output logic [SLOTS-1:0][IDX_W-1:0] idx,
    output logic [SLOTS-1:0]            found,
    output logic                        spill
);

    logic [NCOL-1:0] residue [0:SLOTS];

    function automatic logic [IDX_W-1:0] low_pos(input logic [NCOL-1:0] v);
        logic [IDX_W-1:0] p;
        p = '0;
        for (int i = NCOL - 1; i >= 0; i--) begin
            if (v[i]) p = IDX_W'(i);
        end
        return p;
    endfunction

    assign residue[0] = hits;

    for (genvar k = 0; k < SLOTS; k++) begin : g_stage
        assign found[k]     = |residue[k];
        assign idx[k]       = low_pos(residue[k]);
        assign residue[k+1] = residue[k] & (residue[k] - NCOL'(1));
    end

    assign spill = |residue[SLOTS];

endmodule

// File: rtl/stub_event_file.sv
`timescale 1ns/1ps
module stub_event_file
    import stub_pkg::*;
#(
    parameter int SLOTS = 7,
    parameter int IDX_W = 7,
    parameter int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load,
    input  logic [SLOTS-1:0][IDX_W-1:0] idx,
    input  logic [SLOTS-1:0]            found,
    input  logic                        spill,
    input  evt_meta_t                   meta,
    output logic [SLOTS-1:0][IDX_W-1:0] idx_q,
    output logic [CNT_W-1:0]            cnt_q,
    output logic                        trunc_q,
    output evt_meta_t                   meta_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            cnt_q   <= '0;
            trunc_q <= 1'b0;
            meta_q  <= '0;
        end else if (load) begin
            idx_q   <= idx;
            cnt_q   <= CNT_W'($countones(found));
            trunc_q <= spill;
            meta_q  <= meta;
        end
    end

endmodule

// File: rtl/stub_frame_emitter.sv
`timescale 1ns/1ps
module stub_frame_emitter
    import stub_pkg::*;
#(
    parameter int SLOTS = 7,
    parameter int IDX_W = 7,
    parameter int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load,
    input  logic [SLOTS-1:0][IDX_W-1:0] idx_q,
    input  logic [CNT_W-1:0]            cnt_q,
    input  logic                        trunc_q,
    input  evt_meta_t                   meta_q,
    input  logic                        out_ready,
    output logic                        out_valid,
    output logic [WORD_W-1:0]           out_data,
    output logic                        out_last
);

    logic             busy;
    logic [CNT_W-1:0] ptr;
    logic [IDX_W-1:0] sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            ptr  <= '0;
        end else if (load) begin
            busy <= 1'b1;
            ptr  <= '0;
        end else if (busy && out_ready) begin
            if (ptr == cnt_q) begin
                busy <= 1'b0;
            end else begin
                ptr <= ptr + CNT_W'(1);
            end
        end
    end

    always_comb begin
        sel = idx_q[0];
        for (int k = 0; k < SLOTS; k++) begin
            if (ptr == CNT_W'(k + 1)) sel = idx_q[k];
        end
    end

    always_comb begin
        if (ptr == '0) begin
            out_data = pack_hdr(trunc_q, LEN_W'(cnt_q), meta_q.bx);
        end else begin
            out_data = pack_stub(PHI_W'(sel), meta_q);
        end
    end

    assign out_valid = busy;
    assign out_last  = busy && (ptr == cnt_q);

endmodule

// File: rtl/stub_event_packer.sv
`timescale 1ns/1ps
module stub_event_packer
    import stub_pkg::*;
#(
    parameter int NCOL  = COLS,
    parameter int SLOTS = MAX_STUBS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_valid,
    input  logic [NCOL-1:0]   evt_hits,
    input  logic [BX_W-1:0]   evt_bx,
    input  logic [TAG_W-1:0]  evt_chip,
    input  logic [TAG_W-1:0]  evt_zcol,
    input  logic              evt_side,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_last,
    output logic              evt_dropped
);

    localparam int IDX_W = $clog2(NCOL);
    localparam int CNT_W = $clog2(SLOTS + 1);

    logic [SLOTS-1:0][IDX_W-1:0] chain_idx;
    logic [SLOTS-1:0]            chain_found;
    logic                        chain_spill;
    logic [SLOTS-1:0][IDX_W-1:0] file_idx;
    logic [CNT_W-1:0]            file_cnt;
    logic                        file_trunc;
    evt_meta_t                   meta_in;
    evt_meta_t                   file_meta;
    logic                        load;

    always_comb begin
        meta_in.bx   = evt_bx;
        meta_in.chip = evt_chip;
        meta_in.zcol = evt_zcol;
        meta_in.side = evt_side;
    end

    assign load = evt_valid && !out_valid;

    always_ff @(posedge clk) begin
        if (rst) evt_dropped <= 1'b0;
        else     evt_dropped <= evt_valid && out_valid;
    end

    stub_prio_chain #(.NCOL(NCOL), .SLOTS(SLOTS), .IDX_W(IDX_W)) u_chain (
        .hits  (evt_hits),
        .idx   (chain_idx),
        .found (chain_found),
        .spill (chain_spill)
    );

    stub_event_file #(.SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_file (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .idx     (chain_idx),
        .found   (chain_found),
        .spill   (chain_spill),
        .meta    (meta_in),
        .idx_q   (file_idx),
        .cnt_q   (file_cnt),
        .trunc_q (file_trunc),
        .meta_q  (file_meta)
    );

    stub_frame_emitter #(.SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_emit (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .idx_q     (file_idx),
        .cnt_q     (file_cnt),
        .trunc_q   (file_trunc),
        .meta_q    (file_meta),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last)
    );

endmodule

// File: rtl/stub_event_packer_chk.sv
`timescale 1ns/1ps
module stub_event_packer_chk #(
    parameter int SLOTS = 7
) (
    input logic        clk,
    input logic        rst,
    input logic        evt_valid,
    input logic        out_ready,
    input logic        out_valid,
    input logic [15:0] out_data,
    input logic        out_last,
    input logic        evt_dropped
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!out_valid && !evt_dropped)); // R1

    AST_TRUNC_FULL_LEN: assert property (@(posedge clk) disable iff (rst)
        ($rose(out_valid) && out_data[15]) |-> (out_data[14:12] == 3'(SLOTS))); // R5

    AST_EMPTY_SINGLE_WORD: assert property (@(posedge clk) disable iff (rst)
        ($rose(out_valid) && out_data[14:12] == 3'd0) |-> (out_last && !out_data[15])); // R6

    AST_LAST_ENDS_FRAME: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> !out_valid); // R7

    AST_DROP_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && out_valid) |=> evt_dropped); // R8

    AST_DROP_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        evt_dropped |-> $past(evt_valid && out_valid)); // R8

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R9

    AST_HEADER_NEXT: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && !out_valid) |=> out_valid); // R10

endmodule

bind stub_event_packer stub_event_packer_chk #(.SLOTS(SLOTS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .evt_valid   (evt_valid),
    .out_ready   (out_ready),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_last    (out_last),
    .evt_dropped (evt_dropped)
);

// File: tb/stub_event_packer_bench.sv
`timescale 1ns/1ps
module stub_event_packer_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         evt_valid = 1'b0;
    logic [127:0] evt_hits = '0;
    logic [11:0]  evt_bx = '0;
    logic [3:0]   evt_chip = '0;
    logic [3:0]   evt_zcol = '0;
    logic         evt_side = 1'b0;
    logic         out_ready = 1'b1;
    logic         out_valid;
    logic [15:0]  out_data;
    logic         out_last;
    logic         evt_dropped;

    int checks = 0;
    int fails  = 0;
    bit rnd_ready = 0;
    bit done = 0;
    string cur_tag = "R3";

    logic [15:0] wq[$];
    string       lq[$];
    bit          exp_drop = 0;

    always #2 clk = ~clk;

    stub_event_packer u_stub_event_packer (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_hits(evt_hits),
        .evt_bx(evt_bx), .evt_chip(evt_chip), .evt_zcol(evt_zcol),
        .evt_side(evt_side), .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last), .evt_dropped(evt_dropped)
    );

    // Behavioural model: builds the expected frame from the requirements (R2..R6).
    function automatic void build_frame();
        int n = 0;
        for (int i = 0; i < 128; i++) begin
            if (evt_hits[i]) begin
                n++;
                if (n <= 7) begin
                    wq.push_back({i[6:0], evt_side, evt_zcol, evt_chip}); // R4 layout
                    lq.push_back({"R4/", cur_tag});
                end
            end
        end
        wq.push_front({(n > 7), 3'((n > 7) ? 7 : n), evt_bx}); // R3 layout
        lq.push_front({"R3/", cur_tag});
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            wq.delete();
            lq.delete();
            exp_drop = 0;
        end else begin
            bit pend;
            pend = (wq.size() != 0);
            exp_drop = evt_valid && pend;   // R8
            if (pend && out_ready) begin
                void'(wq.pop_front());
                void'(lq.pop_front());
            end
            if (evt_valid && !pend) build_frame();
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            bit ev;
            ev = (wq.size() != 0);
            check(out_valid == ev, "R10 valid", 32'(out_valid), 32'(ev));
            if (ev && out_valid) begin
                check(out_data == wq[0], out_ready ? lq[0] : {"R9/", lq[0]}, 32'(out_data), 32'(wq[0]));
                check(out_last == (wq.size() == 1), "R7 last", 32'(out_last), 32'(wq.size() == 1));
            end
            check(evt_dropped == exp_drop, "R8 drop", 32'(evt_dropped), 32'(exp_drop));
        end
        out_ready <= rnd_ready ? 1'($urandom_range(0, 1)) : 1'b1;
    end

    task automatic send(input logic [127:0] h, input string tag);
        cur_tag = tag;
        evt_hits = h;
        evt_bx = 12'($urandom);
        evt_chip = 4'($urandom);
        evt_zcol = 4'($urandom);
        evt_side = 1'($urandom);
        evt_valid = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (wq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: quiet outputs during reset
        check(!out_valid && !evt_dropped, "R1 reset", 32'({out_valid, evt_dropped}), 32'd0);
        @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && !evt_dropped, "R1 after reset", 32'({out_valid, evt_dropped}), 32'd0);

        send('0, "R6 empty"); drain();
        send(128'd1, "R2 bit0"); drain();
        send(128'd1 << 127, "R2 bit127"); drain();
        send((128'd1 << 5) | (128'd1 << 64) | (128'd1 << 100), "R2 three"); drain();
        send(128'h7F << 60, "R5 exactly7"); drain();
        send(128'hFF << 3, "R5 eight"); drain();
        send({128{1'b1}}, "R5 allones"); drain();
        send(128'h8000_0000_0000_0001_0000_0000_0000_0000, "R4 fields"); drain();

        // R8: second offer while the first frame is pending is dropped
        send(128'h3, "R8 first");
        send(128'hF0, "R8 refused");
        drain();

        // R9: random stalls on the output
        rnd_ready = 1;
        for (int i = 0; i < 12; i++) begin
            send(rnd128() & rnd128(), "R9 stall");
            drain();
        end

        // R10/R8: random offers every cycle with random ready
        for (int c = 0; c < 600; c++) begin
            @(negedge clk);
            cur_tag = "R10 stream";
            evt_valid = ($urandom_range(0, 2) == 0);
            case ($urandom_range(0, 3))
                0: evt_hits = '0;
                1: evt_hits = rnd128();
                2: evt_hits = rnd128() & rnd128() & rnd128();
                default: evt_hits = 128'd1 << $urandom_range(0, 127);
            endcase
            evt_bx = 12'($urandom);
            evt_chip = 4'($urandom);
            evt_zcol = 4'($urandom);
            evt_side = 1'($urandom);
        end
        evt_valid = 1'b0;
        drain();
        rnd_ready = 0;
        drain();

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule